// File: doc/BRIEF.md
# Coincident-Current Core Plane Cycle Sequencer

This block sits between a simple host request port and the analog drive electronics of a single magnetic core plane that stores one bit per word. A host request names an address, a direction and, for a store, one bit of data. The block turns it into timed digital strobes. The address picks one X line and one Y line. A direction flag selects the polarity of the drive current. An inhibit enable keeps the addressed core from switching. A sampling window tells when the sense amplifier output is meaningful.

Reading a core always clears it, so every access has two phases. The first phase is a destructive read, which leaves the addressed core at 0 and records whether a sense pulse arrived. The second phase is a write. It restores the sensed bit for a host read, or stores the host bit for a host write. A 1 is written by leaving inhibit off. A 0 is kept by holding inhibit on for the whole write phase. Each phase has a setup, a drive and a recovery interval, and each interval has its own cycle count. The host sees the result only after the second phase has ended.

Top module: `core_seq_ctrl`

## Requirements
- R1: `req_ready` is 1 only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 in the next cycle. Requests presented while busy are not accepted and change no core.
- R2: The low `X_BITS` address bits select X line `x_sel[addr[X_BITS-1:0]]` and the upper `Y_BITS` bits select Y line `y_sel[addr[ADDR_W-1:X_BITS]]`. While `drive_en` is 1, exactly one bit of `x_sel` and exactly one bit of `y_sel` are set. While `drive_en` is 0, both are all zero.
- R3: An access runs these phases in order: read setup, read drive, read recovery, write setup, write drive, write recovery. Their lengths are `SETUP_CYC`, `DRIVE_CYC` and `RECOVER_CYC`, so the access lasts 2*(SETUP_CYC+DRIVE_CYC+RECOVER_CYC) cycles. `drive_dir` is 0 during the read drive and 1 during the write drive.
- R4: `sense_in` is sampled only while `sense_win` is 1. `sense_win` covers the read-drive cycles with index SENSE_START to SENSE_START+SENSE_LEN-1, counting from 0. A value of 1 on `sense_in` outside this window has no effect on the result.
- R5: For a host read (`req_write`=0), the write phase stores the bit that was sensed, so the core keeps its content.
- R6: For a host write (`req_write`=1), the write phase stores `req_wdata`. `inhibit` is 1 through the write setup, drive and recovery intervals exactly when the bit to store is 0, and `inhibit` is never 1 while a read drive is active.
- R7: `rsp_done` is a one-cycle pulse in the first idle cycle after write recovery. `rsp_rdata` then holds the sensed bit, which is the previous content of the core for both reads and writes, and keeps it until the next pulse.
- R8: Cores that share only the X line or only the Y line of the addressed core never change.
- R9: A synchronous reset returns the block to idle. After reset `req_ready`=1, and `drive_en`, `inhibit`, `sense_win`, `rsp_done`, `x_sel` and `y_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = store `req_wdata`, 0 = read |
| req_addr | input | ADDR_W | Word address, with the Y line index above the X line index |
| req_wdata | input | 1 | Bit to store on a write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 1 | Sensed bit of the last access |
| x_sel | output | NX | One-hot X line select |
| y_sel | output | NY | One-hot Y line select |
| drive_en | output | 1 | Drive current on the selected lines |
| drive_dir | output | 1 | Drive polarity: 0 = read, 1 = write |
| inhibit | output | 1 | Inhibit current enable (keep core at 0) |
| sense_win | output | 1 | Sense sampling window strobe |
| sense_in | input | 1 | Digitised sense amplifier output |

## Verification
Some properties are checked by the assertions on every cycle. One X line and one Y line are selected during a drive and none otherwise. The selects stay stable across a drive. The sampling window only opens inside a read drive. Inhibit holds steady through a write drive and never overlaps a read drive. `rsp_done` is a single-cycle pulse. Nothing drives while the block reports ready. Other behaviour can only be shown by the bench, which runs a behavioural core plane. That behaviour is whether a read really restores its data, whether a write stores the right polarity, whether half-selected cores stay untouched, whether sense noise outside the window is ignored, and how long an access takes.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SET,
    ST_RD_DRV,
    ST_RD_REC,
    ST_WR_SET,
    ST_WR_DRV,
    ST_WR_REC
  } seq_state_e;

  function automatic logic is_drive(input seq_state_e s);
    return (s == ST_RD_DRV) || (s == ST_WR_DRV);
  endfunction

  function automatic logic is_write_phase(input seq_state_e s);
    return (s == ST_WR_SET) || (s == ST_WR_DRV) || (s == ST_WR_REC);
  endfunction

endpackage

// File: rtl/core_seq_fsm.sv
module core_seq_fsm
  import core_seq_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int DRIVE_CYC   = 4,
  parameter int RECOVER_CYC = 2,
  parameter int CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);

  int   phase_len;
  logic phase_last;

  always_comb begin
    case (state_q)
      ST_RD_SET, ST_WR_SET: phase_len = SETUP_CYC;
      ST_RD_DRV, ST_WR_DRV: phase_len = DRIVE_CYC;
      default:              phase_len = RECOVER_CYC;
    endcase
    phase_last = (int'(cnt_q) == phase_len - 1);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (state_q == ST_IDLE) begin
      cnt_d = '0;
      if (start) state_d = ST_RD_SET;
    end else if (phase_last) begin
      cnt_d = '0;
      case (state_q)
        ST_RD_SET: state_d = ST_RD_DRV;
        ST_RD_DRV: state_d = ST_RD_REC;
        ST_RD_REC: state_d = ST_WR_SET;
        ST_WR_SET: state_d = ST_WR_DRV;
        ST_WR_DRV: state_d = ST_WR_REC;
        default:   state_d = ST_IDLE;
      endcase
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/core_line_dec.sv
module core_line_dec #(
  parameter  int SEL_W = 2,
  localparam int LINES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] idx,
  input  logic             en,
  output logic [LINES-1:0] onehot
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign onehot[i] = en && (idx == SEL_W'(i));
  end

endmodule

// File: rtl/core_sense_cap.sv
module core_sense_cap
  import core_seq_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int SENSE_START = 1,
  parameter int SENSE_LEN   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  seq_state_e       state_d,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             sense_in,
  output logic             win_q,
  output logic             bit_q
);

  logic win_d;

  always_comb begin
    win_d = (state_d == ST_RD_DRV) &&
            (int'(cnt_d) >= SENSE_START) &&
            (int'(cnt_d) < SENSE_START + SENSE_LEN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      win_q <= win_d;
      if (clear)                  bit_q <= 1'b0;
      else if (win_q && sense_in) bit_q <= 1'b1;
    end
  end

endmodule

// File: rtl/core_seq_ctrl.sv
module core_seq_ctrl
  import core_seq_pkg::*;
#(
  parameter  int X_BITS      = 2,
  parameter  int Y_BITS      = 2,
  parameter  int SETUP_CYC   = 2,
  parameter  int DRIVE_CYC   = 4,
  parameter  int RECOVER_CYC = 2,
  parameter  int SENSE_START = 1,
  parameter  int SENSE_LEN   = 2,
  localparam int NX          = 1 << X_BITS,
  localparam int NY          = 1 << Y_BITS,
  localparam int ADDR_W      = X_BITS + Y_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rsp_done,
  output logic              rsp_rdata,
  output logic [NX-1:0]     x_sel,
  output logic [NY-1:0]     y_sel,
  output logic              drive_en,
  output logic              drive_dir,
  output logic              inhibit,
  output logic              sense_win,
  input  logic              sense_in
);

  localparam int MAX_A   = (SETUP_CYC > DRIVE_CYC) ? SETUP_CYC : DRIVE_CYC;
  localparam int MAX_LEN = (MAX_A > RECOVER_CYC) ? MAX_A : RECOVER_CYC;
  localparam int CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              accept;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic              write_q, wdata_q;
  logic              sensed_q;
  logic              store_bit;
  logic              drive_nx;
  logic              done_nx;
  logic [NX-1:0]     x_nx;
  logic [NY-1:0]     y_nx;

  assign accept  = req_valid && req_ready;
  assign addr_nx = accept ? req_addr : addr_q;

  core_seq_fsm #(
    .SETUP_CYC  (SETUP_CYC),
    .DRIVE_CYC  (DRIVE_CYC),
    .RECOVER_CYC(RECOVER_CYC),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .start  (accept),
    .state_q(state_q),
    .state_d(state_d),
    .cnt_q  (cnt_q),
    .cnt_d  (cnt_d)
  );

  core_sense_cap #(
    .CNT_W      (CNT_W),
    .SENSE_START(SENSE_START),
    .SENSE_LEN  (SENSE_LEN)
  ) u_sense (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept),
    .state_d (state_d),
    .cnt_d   (cnt_d),
    .sense_in(sense_in),
    .win_q   (sense_win),
    .bit_q   (sensed_q)
  );

  assign drive_nx = is_drive(state_d);

  core_line_dec #(.SEL_W(X_BITS)) u_xdec (
    .idx   (addr_nx[X_BITS-1:0]),
    .en    (drive_nx),
    .onehot(x_nx)
  );

  core_line_dec #(.SEL_W(Y_BITS)) u_ydec (
    .idx   (addr_nx[ADDR_W-1:X_BITS]),
    .en    (drive_nx),
    .onehot(y_nx)
  );

  // Bit to leave in the core after the write phase.
  assign store_bit = write_q ? wdata_q : sensed_q;
  assign done_nx   = (state_q == ST_WR_REC) && (state_d == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      write_q   <= 1'b0;
      wdata_q   <= 1'b0;
      req_ready <= 1'b1;
      drive_en  <= 1'b0;
      drive_dir <= 1'b0;
      inhibit   <= 1'b0;
      x_sel     <= '0;
      y_sel     <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        write_q <= req_write;
        wdata_q <= req_wdata;
      end
      req_ready <= (state_d == ST_IDLE);
      drive_en  <= drive_nx;
      drive_dir <= is_write_phase(state_d);
      inhibit   <= is_write_phase(state_d) && !store_bit;
      x_sel     <= x_nx;
      y_sel     <= y_nx;
      rsp_done  <= done_nx;
      if (done_nx) rsp_rdata <= sensed_q;
    end
  end

endmodule

// File: rtl/core_seq_chk.sv
module core_seq_chk #(
  parameter int NX = 4,
  parameter int NY = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [NX-1:0] x_sel,
  input logic [NY-1:0] y_sel,
  input logic          drive_en,
  input logic          drive_dir,
  input logic          inhibit,
  input logic          sense_win,
  input logic          rsp_done
);

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !drive_en && !inhibit);

  // R2
  single_line_chk: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> ($countones(x_sel) == 1) && ($countones(y_sel) == 1));

  // R2
  no_line_chk: assert property (@(posedge clk) disable iff (rst)
    !drive_en |-> (x_sel == '0) && (y_sel == '0));

  // R3
  sel_steady_chk: assert property (@(posedge clk) disable iff (rst)
    drive_en && $past(drive_en) |-> $stable(x_sel) && $stable(y_sel));

  // R4
  win_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    sense_win |-> drive_en && !drive_dir);

  // R6
  inhibit_steady_chk: assert property (@(posedge clk) disable iff (rst)
    drive_en && drive_dir && $past(drive_en && drive_dir) |-> $stable(inhibit));

  // R6
  inhibit_not_read_chk: assert property (@(posedge clk) disable iff (rst)
    inhibit |-> !(drive_en && !drive_dir));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

endmodule

bind core_seq_ctrl core_seq_chk #(.NX(NX), .NY(NY)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .x_sel    (x_sel),
  .y_sel    (y_sel),
  .drive_en (drive_en),
  .drive_dir(drive_dir),
  .inhibit  (inhibit),
  .sense_win(sense_win),
  .rsp_done (rsp_done)
);

// File: tb/sim_core_seq_ctrl.sv
module sim_core_seq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int XB = 2;
  localparam int YB = 2;
  localparam int NX = 1 << XB;
  localparam int NY = 1 << YB;
  localparam int AW = XB + YB;
  localparam int NCELL = NX * NY;
  localparam int S_C = 2;
  localparam int D_C = 4;
  localparam int R_C = 2;
  localparam int EXP_LAT = 2 * (S_C + D_C + R_C);

  // Vector: {write, addr[3:0], wdata, expected rdata}
  localparam int NVEC = 12;
  localparam logic [6:0] VEC [NVEC] = '{
    {1'b1, 4'd5,  1'b1, 1'b0},
    {1'b1, 4'd10, 1'b1, 1'b0},
    {1'b0, 4'd5,  1'b0, 1'b1},
    {1'b0, 4'd5,  1'b0, 1'b1},
    {1'b0, 4'd10, 1'b0, 1'b1},
    {1'b1, 4'd5,  1'b0, 1'b1},
    {1'b0, 4'd5,  1'b0, 1'b0},
    {1'b0, 4'd0,  1'b0, 1'b0},
    {1'b1, 4'd15, 1'b1, 1'b0},
    {1'b1, 4'd15, 1'b1, 1'b1},
    {1'b0, 4'd15, 1'b0, 1'b1},
    {1'b0, 4'd10, 1'b0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_wdata = 1'b0;
  logic          req_ready, rsp_done, rsp_rdata;
  logic [NX-1:0] x_sel;
  logic [NY-1:0] y_sel;
  logic          drive_en, drive_dir, inhibit, sense_win;
  logic          sense_in;
  logic          noise_en = 1'b0;

  int checks = 0;
  int fails  = 0;

  // Behavioural core plane
  logic [NCELL-1:0] core_m   = '0;
  logic [NCELL-1:0] clr_mask = '0;
  logic [NCELL-1:0] full_mask;
  logic [NCELL-1:0] shadow   = '0;

  always_comb begin
    for (int j = 0; j < NY; j++)
      for (int i = 0; i < NX; i++)
        full_mask[j*NX+i] = x_sel[i] && y_sel[j];
  end

  assign sense_in = (drive_en && !drive_dir && |(full_mask & core_m)) ||
                    (noise_en && !drive_en);

  always @(posedge clk) begin
    if (drive_en && !drive_dir) begin
      clr_mask <= clr_mask | full_mask;
    end else if (!drive_en && clr_mask != '0) begin
      core_m   <= core_m & ~clr_mask;
      clr_mask <= '0;
    end else if (drive_en && drive_dir && !inhibit) begin
      core_m <= core_m | full_mask;
    end
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  core_seq_ctrl #(
    .X_BITS(XB), .Y_BITS(YB),
    .SETUP_CYC(S_C), .DRIVE_CYC(D_C), .RECOVER_CYC(R_C),
    .SENSE_START(1), .SENSE_LEN(2)
  ) u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .x_sel(x_sel), .y_sel(y_sel),
    .drive_en(drive_en), .drive_dir(drive_dir),
    .inhibit(inhibit), .sense_win(sense_win), .sense_in(sense_in)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [AW-1:0] a, input logic d,
                        output logic rd, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done && lat < 200) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    rd = rsp_rdata;
    if (w) shadow[a] = d;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic rd;
    int lat;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(req_ready && !drive_en && !inhibit && !sense_win && !rsp_done &&
          x_sel == '0 && y_sel == '0, "R9 reset outputs",
          {req_ready, drive_en, inhibit, rsp_done}, 4'b1000);

    // Vector table: R5 R6 R7 R8 and R3 latency
    for (int v = 0; v < NVEC; v++) begin
      access(VEC[v][6], VEC[v][5:2], VEC[v][1], rd, lat);
      check(rd == VEC[v][0], "R7 rdata", rd, VEC[v][0]);
      check(lat == EXP_LAT, "R3 access length", lat, EXP_LAT);
      check(core_m == shadow, VEC[v][6] ? "R6 R8 plane after write" : "R5 R8 plane after read",
            core_m, shadow);
    end

    // R7: rdata held after the done pulse
    @(negedge clk);
    check(!rsp_done && rsp_rdata == 1'b1, "R7 pulse width and hold", {rsp_done, rsp_rdata}, 1);

    // R4: sense noise outside the window is ignored (addr 0 holds 0)
    noise_en = 1'b1;
    access(1'b0, 4'd0, 1'b0, rd, lat);
    noise_en = 1'b0;
    check(rd == 1'b0, "R4 noise outside window", rd, 0);
    check(core_m == shadow, "R4 plane after noisy read", core_m, shadow);

    // R1: a request held while busy is not taken
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd3; req_wdata = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_write = 1'b1; req_addr = 4'd6; req_wdata = 1'b1;
    check(!req_ready, "R1 ready low while busy", req_ready, 0);
    lat = 0;
    while (!rsp_done && lat < 200) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(req_ready && core_m == shadow, "R1 busy request ignored", core_m, shadow);

    // R9: reset in the middle of an access
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd9; req_wdata = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(req_ready && !drive_en && !inhibit, "R9 reset mid access",
          {req_ready, drive_en, inhibit}, 3'b100);
    repeat (EXP_LAT + 2) @(negedge clk);
    check(!rsp_done && core_m == shadow, "R9 aborted access left plane", core_m, shadow);

    // R2: selects follow the address split (addr 6 -> x=2, y=1)
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd6;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!drive_en) @(negedge clk);
    check(x_sel == 4'b0100 && y_sel == 4'b0010 && !drive_dir, "R2 line decode",
          {x_sel, y_sel}, 8'b0100_0010);
    while (!rsp_done) @(negedge clk);
    check(rsp_rdata == 1'b0, "R5 read of empty core", rsp_rdata, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule